// File: doc/BRIEF.md
# Annunciator Blink Driver

This block drives a small set of annunciator segments from one packed mode register. Each annunciator owns a 2-bit field in that register, and the field picks one of four behaviours: dark, lit in the first half of the blink period, lit in the second half, or lit steadily. Two annunciators given the two opposite half-period codes light in turn, so they appear to alternate.

A shared phase generator counts multiplex ticks, which are single-cycle enables from the display scan clock, and flips a phase flag at the end of every half period. One rate-select input sets the blink speed for every channel: low gives the slow rate and high gives a rate twice as fast. When the rate select changes, the tick counter starts again from zero. The phase itself does not change at that moment. A shutdown input turns every segment dark without touching the stored modes, so the display shows the same pattern again once shutdown is released.

Top module: `annun_blink_top`

## Requirements
- R1: Annunciator k (k = 0..3) takes its mode from register bits [2k+1:2k]. Channel 0 uses bits 1:0 and drives seg_en[0], and channel 3 uses bits 7:6 and drives seg_en[3].
- R2: Mode code 2'b00 keeps the segment dark in both blink phases.
- R3: Mode code 2'b01 lights the segment only while blink_phase is 0, which is the first half of the period.
- R4: Mode code 2'b10 lights the segment only while blink_phase is 1, which is the second half of the period.
- R5: Mode code 2'b11 lights the segment in both phases.
- R6: blink_phase inverts on the 2^(BLINK_N-1)-th tick of a half period when rate_sel is 0, and on the 2^(BLINK_N-2)-th tick when rate_sel is 1. The full blink period is therefore 2^BLINK_N or 2^(BLINK_N-1) ticks.
- R7: Only cycles with mux_tick high advance the half-period count. Cycles without a tick leave blink_phase unchanged.
- R8: In a cycle where rate_sel differs from its value in the previous cycle, the tick count returns to zero and the tick in that cycle is discarded. blink_phase keeps its value, so the next half period has its full length.
- R9: While shutdown is high, all of seg_en is 0. The mode register keeps its contents, and the segments resume the stored pattern once shutdown falls.
- R10: Synchronous reset clears the mode register, the tick count, the phase and the remembered rate select, so all segments are dark and blink_phase is 0.
- R11: A cycle with reg_wr high loads reg_wdata, and the new modes drive the segments after that clock edge. A cycle without reg_wr leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe for the mode register |
| reg_wdata | input | 8 | Packed modes, 2 bits per annunciator |
| mux_tick | input | 1 | Single-cycle multiplex tick enable |
| rate_sel | input | 1 | 0 selects the slow blink rate, 1 the fast rate |
| shutdown | input | 1 | Forces every segment dark while high |
| seg_en | output | 4 | Segment enables, one per annunciator |
| blink_phase | output | 1 | 0 in the first half of the period, 1 in the second |

## Verification
The bench builds the block with BLINK_N = 3. A half period is then 4 ticks at the slow rate and 2 at the fast rate, so one run covers many phase inversions at both rates, a rate change in the middle of a count, and blinking with idle cycles between ticks. The four channels are loaded with the four different codes together, so a single vector compares all four behaviours against the same phase. Shutdown is also applied while ticks are still running, which shows that the phase keeps advancing behind dark segments.

// File: rtl/annun_pkg.sv
package annun_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_DARK   = 2'b00,
    MODE_FIRST  = 2'b01,
    MODE_SECOND = 2'b10,
    MODE_STEADY = 2'b11
  } ann_mode_e;

  // Whether a channel in mode m is lit during blink phase ph.
  function automatic logic mode_lit(input ann_mode_e m, input logic ph);
    logic lit;
    case (m)
      MODE_DARK:   lit = 1'b0;
      MODE_FIRST:  lit = ~ph;
      MODE_SECOND: lit = ph;
      default:     lit = 1'b1;
    endcase
    return lit;
  endfunction

  // Ticks in one half period for a given exponent and rate choice.
  function automatic int unsigned half_len(input int unsigned n, input logic fast);
    return fast ? (32'd1 << (n - 2)) : (32'd1 << (n - 1));
  endfunction

endpackage

// File: rtl/annun_mode_reg.sv
module annun_mode_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] modes_q
);

  always_ff @(posedge clk) begin
    if (rst)        modes_q <= '0;
    else if (wr_en) modes_q <= wr_data;
  end

  assert_hold_without_write_R11: assert property (
    @(posedge clk) disable iff (rst)
    !wr_en |=> $stable(modes_q));

  assert_load_on_write_R11: assert property (
    @(posedge clk) disable iff (rst)
    wr_en |=> (modes_q == $past(wr_data)));

endmodule

// File: rtl/annun_blink_gen.sv
module annun_blink_gen
  import annun_pkg::*;
#(
  parameter int BLINK_N = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rate_sel,
  output logic phase,
  output logic toggle_evt,
  output logic restart_evt
);

  localparam int unsigned SLOW_HALF = half_len(BLINK_N, 1'b0);
  localparam int unsigned FAST_HALF = half_len(BLINK_N, 1'b1);
  localparam int CNT_W = (SLOW_HALF > 1) ? $clog2(SLOW_HALF) : 1;
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_HALF - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_HALF - 1);

  logic [CNT_W-1:0] cnt;
  logic             rate_q;
  logic [CNT_W-1:0] last_cnt;
  logic             at_last;

  assign last_cnt    = rate_sel ? FAST_LAST : SLOW_LAST;
  assign at_last     = (cnt == last_cnt);
  assign restart_evt = (rate_sel != rate_q);
  assign toggle_evt  = tick && at_last && !restart_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      phase  <= 1'b0;
      rate_q <= 1'b0;
    end else begin
      rate_q <= rate_sel;
      if (restart_evt) begin
        cnt <= '0;
      end else if (tick) begin
        if (at_last) begin
          cnt   <= '0;
          phase <= ~phase;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assert_cnt_in_range_R6: assert property (
    @(posedge clk) disable iff (rst)
    cnt <= (rate_q ? FAST_LAST : SLOW_LAST));

  assert_toggle_wraps_R6: assert property (
    @(posedge clk) disable iff (rst)
    toggle_evt |=> (cnt == '0) && (phase != $past(phase)));

  assert_idle_holds_phase_R7: assert property (
    @(posedge clk) disable iff (rst)
    !tick |=> $stable(phase));

  assert_restart_clears_R8: assert property (
    @(posedge clk) disable iff (rst)
    restart_evt |=> (cnt == '0) && $stable(phase));

endmodule

// File: rtl/annun_channel.sv
module annun_channel
  import annun_pkg::*;
(
  input  ann_mode_e mode,
  input  logic      phase,
  input  logic      shutdown,
  output logic      seg
);

  always_comb begin
    seg = !shutdown && mode_lit(mode, phase);
  end

endmodule

// File: rtl/annun_blink_top.sv
module annun_blink_top
  import annun_pkg::*;
#(
  parameter int NUM_ANN = 4,
  parameter int BLINK_N = 6,
  localparam int DATA_W = NUM_ANN * MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              mux_tick,
  input  logic              rate_sel,
  input  logic              shutdown,
  output logic [NUM_ANN-1:0] seg_en,
  output logic              blink_phase
);

  logic [DATA_W-1:0] modes_q;
  logic              toggle_evt;
  logic              restart_evt;

  annun_mode_reg #(.DATA_W(DATA_W)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr),
    .wr_data (reg_wdata),
    .modes_q (modes_q)
  );

  annun_blink_gen #(.BLINK_N(BLINK_N)) u_blink (
    .clk         (clk),
    .rst         (rst),
    .tick        (mux_tick),
    .rate_sel    (rate_sel),
    .phase       (blink_phase),
    .toggle_evt  (toggle_evt),
    .restart_evt (restart_evt)
  );

  for (genvar k = 0; k < NUM_ANN; k++) begin : g_ch
    ann_mode_e mode_k;
    assign mode_k = ann_mode_e'(modes_q[k*MODE_W +: MODE_W]);

    annun_channel u_ch (
      .mode     (mode_k),
      .phase    (blink_phase),
      .shutdown (shutdown),
      .seg      (seg_en[k])
    );

    assert_dark_code_R2: assert property (
      @(posedge clk) disable iff (rst)
      (mode_k == MODE_DARK) |-> !seg_en[k]);

    assert_first_half_R3: assert property (
      @(posedge clk) disable iff (rst)
      (mode_k == MODE_FIRST && !shutdown) |-> (seg_en[k] == !blink_phase));

    assert_second_half_R4: assert property (
      @(posedge clk) disable iff (rst)
      (mode_k == MODE_SECOND && !shutdown) |-> (seg_en[k] == blink_phase));

    assert_steady_on_R5: assert property (
      @(posedge clk) disable iff (rst)
      (mode_k == MODE_STEADY && !shutdown) |-> seg_en[k]);
  end

  assert_shutdown_dark_R9: assert property (
    @(posedge clk) disable iff (rst)
    shutdown |-> (seg_en == '0));

  assert_no_toggle_on_restart_R8: assert property (
    @(posedge clk) disable iff (rst)
    restart_evt |-> !toggle_evt);

  assert_reset_state_R10: assert property (
    @(posedge clk)
    rst |=> (seg_en == '0) && !blink_phase);

endmodule

// File: tb/test_annun_blink_top.sv
`timescale 1ns/1ps
module test_annun_blink_top;

  localparam int N = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       mux_tick = 1'b0;
  logic       rate_sel = 1'b0;
  logic       shutdown = 1'b0;
  logic [3:0] seg_en;
  logic       blink_phase;

  always #2 clk = ~clk;

  annun_blink_top #(.NUM_ANN(4), .BLINK_N(N)) i_annun_blink_top (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .mux_tick(mux_tick), .rate_sel(rate_sel), .shutdown(shutdown),
    .seg_en(seg_en), .blink_phase(blink_phase)
  );

  typedef struct {
    logic [3:0] seg;
    logic       ph;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  // Independent model state, built from the requirements.
  int         m_cnt   = 0;
  logic       m_ph    = 0;
  logic       m_rateq = 0;
  logic [7:0] m_reg   = '0;

  function automatic logic lit(input logic [1:0] code, input logic ph);
    if (code == 2'b11) return 1'b1;
    if (code == 2'b01) return ph == 1'b0;
    if (code == 2'b10) return ph == 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input bit rs, input bit tk, input bit rt, input bit sd,
                      input bit wr, input logic [7:0] d, input string tag);
    exp_t e;
    int   half;
    @(negedge clk);
    #1;
    rst = rs; mux_tick = tk; rate_sel = rt; shutdown = sd;
    reg_wr = wr; reg_wdata = d;
    if (rs) begin
      m_cnt = 0; m_ph = 0; m_rateq = 0; m_reg = '0;
    end else begin
      half = rt ? (1 << (N - 2)) : (1 << (N - 1));
      if (rt != m_rateq) m_cnt = 0;
      else if (tk) begin
        if (m_cnt == half - 1) begin m_cnt = 0; m_ph = ~m_ph; end
        else m_cnt++;
      end
      m_rateq = rt;
      if (wr) m_reg = d;
    end
    for (int k = 0; k < 4; k++)
      e.seg[k] = sd ? 1'b0 : lit(m_reg[2*k +: 2], m_ph);
    e.ph  = m_ph;
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (seg_en !== e.seg || blink_phase !== e.ph) begin
        n_fail++;
        $display("FAIL %s: seg_en=%b phase=%b expected seg_en=%b phase=%b",
                 e.tag, seg_en, blink_phase, e.seg, e.ph);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) step(1, 0, 0, 0, 0, 8'h00, "R10 reset");
    step(0, 0, 0, 0, 0, 8'h00, "R10 dark after reset");
    // R1 field layout with all four codes: ch0=00 ch1=01 ch2=10 ch3=11
    step(0, 0, 0, 0, 1, 8'hE4, "R1 write mixed codes");
    // R2..R6 slow rate, ticks back to back
    for (int i = 0; i < 20; i++) step(0, 1, 0, 0, 0, 8'h00, "R6 slow ticks R2 R3 R4 R5");
    // R7 ticks spread out with idle cycles
    for (int i = 0; i < 12; i++) begin
      step(0, 1, 0, 0, 0, 8'h00, "R7 sparse tick");
      step(0, 0, 0, 0, 0, 8'h00, "R7 idle");
      step(0, 0, 0, 0, 0, 8'h00, "R7 idle");
    end
    // R8 rate change on a tick cycle, then fast rate
    step(0, 1, 0, 0, 0, 8'h00, "R8 pre");
    step(0, 1, 1, 0, 0, 8'h00, "R8 rate change drops tick");
    for (int i = 0; i < 12; i++) step(0, 1, 1, 0, 0, 8'h00, "R6 fast ticks");
    // R8 change back in the middle of a count
    step(0, 1, 1, 0, 0, 8'h00, "R8 mid count");
    step(0, 1, 0, 0, 0, 8'h00, "R8 back to slow");
    for (int i = 0; i < 10; i++) step(0, 1, 0, 0, 0, 8'h00, "R8 full half after change");
    // R9 shutdown while ticking, stored modes kept
    for (int i = 0; i < 7; i++) step(0, 1, 0, 1, 0, 8'h00, "R9 shutdown dark");
    for (int i = 0; i < 9; i++) step(0, 1, 0, 0, 0, 8'h00, "R9 resume pattern");
    // R11 write during shutdown, seen after release
    step(0, 0, 0, 1, 1, 8'h1B, "R11 write under shutdown");
    step(0, 0, 0, 0, 0, 8'h00, "R11 new modes after release");
    // R1 further layouts, each code on other channels
    step(0, 0, 0, 0, 1, 8'h1B, "R1 reversed codes");
    for (int i = 0; i < 9; i++) step(0, 1, 1, 0, 0, 8'h00, "R1 reversed blinking");
    step(0, 0, 1, 0, 1, 8'h99, "R1 alternating pair 10/01");
    for (int i = 0; i < 6; i++) step(0, 1, 1, 0, 0, 8'h00, "R3 R4 alternate");
    step(0, 0, 1, 0, 1, 8'hFF, "R5 all steady");
    for (int i = 0; i < 5; i++) step(0, 1, 1, 0, 0, 8'h00, "R5 steady both phases");
    step(0, 0, 1, 0, 1, 8'h00, "R2 all dark");
    for (int i = 0; i < 5; i++) step(0, 1, 1, 0, 0, 8'h00, "R2 dark both phases");
    // R11 no-write cycle with data on bus
    step(0, 0, 1, 0, 1, 8'h55, "R11 load 0x55");
    step(0, 0, 1, 0, 0, 8'hAA, "R11 data ignored without strobe");
    // R10 reset in mid run
    step(0, 1, 1, 0, 0, 8'h00, "R10 pre reset");
    step(1, 1, 1, 0, 0, 8'h00, "R10 mid run reset");
    step(0, 0, 0, 0, 0, 8'h00, "R10 cleared");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule